// File: doc/BRIEF.md
# SDIO Card Interrupt Detector and Read-Wait Controller

This block watches the DAT[1] line of an SD-style card bus and turns the card's interrupt signalling into one interrupt request for the host. There are two ways the card signals an interrupt. On a one-bit bus, DAT[1] carries no data. The card pulls it low for as long as the interrupt is pending, and the request follows that level. On a four-bit bus, DAT[1] is a data line. It is looked at for interrupt status only during a short window that opens straight after the end bit of each block. A low seen in that window is latched and held until software acknowledges it.

The same block runs read-wait. A read-wait request pauses an ongoing block transfer at the next block boundary. The block then raises a suspend signal that freezes the data path's transfer counters and status while the bus clock keeps running. One cycle later it raises a permit signal, so that commands can be issued during the pause. A release ends the pause, and the data path carries on from the values it froze.

Everything is synchronous to the card clock. The asynchronous active-low reset is synchronised internally before it is released.

Top module: `sdio_irq_rw`

## Requirements
- R1: After reset, and until two clock edges after rst_n rises, irq_o, suspend_o and cmd_permit_o are low.
- R2: With wide_bus_i low (one-bit bus), irq_o is high after every clock edge at which dat1_i is sampled low. This holds whatever the block-boundary and transfer inputs are doing.
- R3: With wide_bus_i low, irq_o is low after every clock edge at which dat1_i is sampled high, and irq_ack_i has no effect on irq_o.
- R4: With wide_bus_i high, an edge at which blk_end_i and xfer_active_i are both sampled high opens a window made of the next two clock edges. A low dat1_i sampled at either of those edges makes irq_o high after that edge.
- R5: With wide_bus_i high, a low dat1_i sampled at any edge outside the window does not change irq_o.
- R6: With wide_bus_i high, a latched interrupt keeps irq_o high until an edge at which irq_ack_i is sampled high, and irq_o is low after that edge. If that same edge also samples a low dat1_i inside the window, irq_o stays high.
- R7: A read-wait request (rw_req_i sampled high while xfer_active_i is high) raises suspend_o only after an edge at which blk_end_i is sampled high. That edge can be the one that samples the request or a later one.
- R8: cmd_permit_o goes high exactly one cycle after suspend_o rises, and it is high only while suspend_o is high.
- R9: rw_release_i sampled high makes suspend_o and cmd_permit_o low after that edge. It also cancels a waiting request, and it takes priority over a request sampled at the same edge.
- R10: Once suspend_o is high, further boundaries and requests leave it high until a release. A request still waiting for a boundary is dropped if xfer_active_i is sampled low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat1_i | input | 1 | DAT[1] line as seen at the host |
| wide_bus_i | input | 1 | 1 = four-bit bus, 0 = one-bit bus |
| xfer_active_i | input | 1 | Data path has a block transfer in progress |
| blk_end_i | input | 1 | One-cycle pulse in the cycle holding a block's end bit |
| rw_req_i | input | 1 | Request to pause the transfer at the next boundary |
| rw_release_i | input | 1 | End the read-wait pause |
| irq_ack_i | input | 1 | Software acknowledge of a latched four-bit interrupt |
| irq_o | output | 1 | Card interrupt request |
| suspend_o | output | 1 | Freeze data-path counters and status |
| cmd_permit_o | output | 1 | Commands may be issued during the pause |

## Verification
The properties assume that every input is synchronous to the card clock and is stable around the rising edge. They also assume that blk_end_i is a single-cycle pulse that the data path raises only while a transfer is active. The bench meets both assumptions by driving all inputs on the falling edge. In its random phase it keeps boundary pulses one cycle wide and spaced apart, and it gates them with the transfer-active flag. Requests, releases and acknowledges are mixed freely in that phase, including mode changes in the middle of a transfer. This is done so that the priority rules are exercised as well as the directed sequences.

// File: rtl/sdio_irq_rw_pkg.sv
package sdio_irq_rw_pkg;

  localparam int unsigned IRQ_WIN_CYCLES = 2;

  typedef enum logic [1:0] {
    RW_IDLE  = 2'd0,
    RW_ARMED = 2'd1,
    RW_HOLD  = 2'd2,
    RW_CMD   = 2'd3
  } rw_state_e;

endpackage

// File: rtl/sdio_rst_sync.sv
module sdio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sdio_irq_detect.sv
module sdio_irq_detect #(
  parameter int unsigned WIN_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide_i,
  input  logic act_i,
  input  logic blk_end_i,
  input  logic dat1_i,
  input  logic ack_i,
  output logic irq_o
);

  localparam int unsigned CW = $clog2(WIN_LEN + 1);

  logic win_open;
  logic win_load;

  assign win_load = wide_i & act_i & blk_end_i;

  generate
    if (WIN_LEN == 1) begin : g_flag
      logic open_q;
      logic open_d;

      always_comb begin
        open_d = win_load;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
      end

      assign win_open = open_q;
    end else begin : g_cnt
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_en = win_load | (cnt_q != '0) | ~wide_i;
        cnt_d  = cnt_q;
        if (!wide_i)             cnt_d = '0;
        else if (win_load)       cnt_d = CW'(WIN_LEN);
        else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign win_open = (cnt_q != '0);
    end
  endgenerate

  logic latch_q, latch_d;
  logic irq_q, irq_d;
  logic win_hit;

  always_comb begin
    win_hit = wide_i & win_open & ~dat1_i;
    latch_d = latch_q;
    if (!wide_i)     latch_d = 1'b0;
    else if (win_hit) latch_d = 1'b1;
    else if (ack_i)  latch_d = 1'b0;
    irq_d = wide_i ? latch_d : ~dat1_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/sdio_readwait_fsm.sv
module sdio_readwait_fsm
  import sdio_irq_rw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic blk_end_i,
  input  logic req_i,
  input  logic rel_i,
  output logic suspend_o,
  output logic permit_o
);

  rw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rel_i) begin
      state_d = RW_IDLE;
    end else begin
      unique case (state_q)
        RW_IDLE: begin
          if (req_i && act_i) state_d = blk_end_i ? RW_HOLD : RW_ARMED;
        end
        RW_ARMED: begin
          if (!act_i)         state_d = RW_IDLE;
          else if (blk_end_i) state_d = RW_HOLD;
        end
        RW_HOLD:  state_d = RW_CMD;
        RW_CMD:   state_d = RW_CMD;
        default:  state_d = RW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RW_IDLE;
    else        state_q <= state_d;
  end

  assign suspend_o = (state_q == RW_HOLD) | (state_q == RW_CMD);
  assign permit_o  = (state_q == RW_CMD);

endmodule

// File: rtl/sdio_irq_rw.sv
module sdio_irq_rw
  import sdio_irq_rw_pkg::*;
#(
  parameter int unsigned WIN_LEN     = IRQ_WIN_CYCLES,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dat1_i,
  input  logic wide_bus_i,
  input  logic xfer_active_i,
  input  logic blk_end_i,
  input  logic rw_req_i,
  input  logic rw_release_i,
  input  logic irq_ack_i,
  output logic irq_o,
  output logic suspend_o,
  output logic cmd_permit_o
);

  logic rst_core_n;

  sdio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sdio_irq_detect #(.WIN_LEN(WIN_LEN)) u_irq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wide_i    (wide_bus_i),
    .act_i     (xfer_active_i),
    .blk_end_i (blk_end_i),
    .dat1_i    (dat1_i),
    .ack_i     (irq_ack_i),
    .irq_o     (irq_o)
  );

  sdio_readwait_fsm u_rw (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .act_i     (xfer_active_i),
    .blk_end_i (blk_end_i),
    .req_i     (rw_req_i),
    .rel_i     (rw_release_i),
    .suspend_o (suspend_o),
    .permit_o  (cmd_permit_o)
  );

endmodule

// File: rtl/sdio_irq_rw_chk.sv
module sdio_irq_rw_chk (
  input logic clk,
  input logic rst_n,
  input logic dat1_i,
  input logic wide_bus_i,
  input logic blk_end_i,
  input logic rw_release_i,
  input logic irq_ack_i,
  input logic irq_o,
  input logic suspend_o,
  input logic cmd_permit_o
);

  AST_ONEBIT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_bus_i && !dat1_i) |=> irq_o);                                    // R2

  AST_ONEBIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_bus_i && dat1_i) |=> !irq_o);                                    // R3

  AST_WIDE_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_bus_i && $past(wide_bus_i) && irq_o && !irq_ack_i) |=> irq_o);    // R6

  AST_SUSPEND_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_o) |-> $past(blk_end_i));                                 // R7

  AST_PERMIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_o && !cmd_permit_o && !rw_release_i) |=> cmd_permit_o);        // R8

  AST_PERMIT_NEEDS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_permit_o |-> suspend_o);                                            // R8

  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rw_release_i |=> (!suspend_o && !cmd_permit_o));                       // R9

  AST_SUSPEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_o && !rw_release_i) |=> suspend_o);                            // R10

endmodule

bind sdio_irq_rw sdio_irq_rw_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .dat1_i       (dat1_i),
  .wide_bus_i   (wide_bus_i),
  .blk_end_i    (blk_end_i),
  .rw_release_i (rw_release_i),
  .irq_ack_i    (irq_ack_i),
  .irq_o        (irq_o),
  .suspend_o    (suspend_o),
  .cmd_permit_o (cmd_permit_o)
);

// File: tb/tb_sdio_irq_rw.sv
`timescale 1ns/1ps
module tb_sdio_irq_rw;

  localparam int WIN = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic dat1, wide, act, bend, req, rel, ack;
  logic irq, sus, perm;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;

  // reference model state
  int m_win;
  bit m_latch, m_irq;
  int m_st;   // 0 idle, 1 waiting for boundary, 2 paused, 3 paused with commands

  always #4 clk = ~clk;

  sdio_irq_rw dut (
    .clk(clk), .rst_n(rst_n), .dat1_i(dat1), .wide_bus_i(wide),
    .xfer_active_i(act), .blk_end_i(bend), .rw_req_i(req),
    .rw_release_i(rel), .irq_ack_i(ack), .irq_o(irq),
    .suspend_o(sus), .cmd_permit_o(perm)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_win = 0; m_latch = 0; m_irq = 0; m_st = 0;
    end else begin
      bit hit;
      int nxt;
      hit = wide && (m_win > 0) && !dat1;
      if (!wide) m_latch = 0;
      else if (hit) m_latch = 1;
      else if (ack) m_latch = 0;
      m_irq = wide ? m_latch : !dat1;
      if (!wide) m_win = 0;
      else if (act && bend) m_win = WIN;
      else if (m_win > 0) m_win = m_win - 1;
      nxt = m_st;
      if (rel) nxt = 0;
      else if (m_st == 0) begin
        if (req && act) nxt = bend ? 2 : 1;
      end else if (m_st == 1) begin
        if (!act) nxt = 0;
        else if (bend) nxt = 2;
      end else nxt = 3;
      m_st = nxt;
    end
  end

  task automatic chk(input string tag, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, actual, expected, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R4 irq against model", irq, m_irq);
      chk("R7 suspend against model", sus, m_st >= 2);
      chk("R8 permit against model", perm, m_st == 3);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; dat1 = 1; wide = 0; act = 0; bend = 0; req = 0; rel = 0; ack = 0;
    tick(3);
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 suspend in reset", sus, 1'b0);
    chk("R1 permit in reset", perm, 1'b0);
    rst_n = 1;
    tick(1);
    dat1 = 0;              // ignored while core reset is still held
    tick(1);
    chk("R1 irq during reset release", irq, 1'b0);
    dat1 = 1;
    tick(3);
    cmp_en = 1'b1;

    // one-bit bus
    dat1 = 0; tick(1);
    chk("R2 level interrupt", irq, 1'b1);
    bend = 1; tick(1); bend = 0;
    chk("R2 independent of boundary", irq, 1'b1);
    ack = 1; tick(1); ack = 0;
    chk("R3 ack ignored", irq, 1'b1);
    dat1 = 1; tick(1);
    chk("R3 drops with line high", irq, 1'b0);

    // four-bit bus
    wide = 1; act = 1; dat1 = 0; tick(3);
    chk("R5 low outside window", irq, 1'b0);
    dat1 = 1; bend = 1; tick(1); bend = 0; tick(2);
    chk("R4 window with line high", irq, 1'b0);
    dat1 = 0; tick(2); dat1 = 1;
    chk("R5 low after window", irq, 1'b0);
    bend = 1; tick(1); bend = 0; tick(1);
    dat1 = 0; tick(1); dat1 = 1;
    chk("R4 second window cycle", irq, 1'b1);
    tick(4);
    chk("R6 latch held", irq, 1'b1);
    ack = 1; tick(1); ack = 0;
    chk("R6 ack clears", irq, 1'b0);
    bend = 1; tick(1); bend = 0;
    dat1 = 0; ack = 1; tick(1); ack = 0; dat1 = 1;
    chk("R6 set beats ack", irq, 1'b1);
    ack = 1; tick(1); ack = 0;
    chk("R6 cleared again", irq, 1'b0);
    bend = 1; tick(1); bend = 0; tick(2);
    dat1 = 0; tick(1); dat1 = 1;
    chk("R5 third cycle outside window", irq, 1'b0);

    // read-wait
    req = 1; tick(1); req = 0; tick(2);
    chk("R7 no pause before boundary", sus, 1'b0);
    bend = 1; tick(1); bend = 0;
    chk("R7 pause at boundary", sus, 1'b1);
    chk("R8 permit not yet", perm, 1'b0);
    tick(1);
    chk("R8 permit one cycle later", perm, 1'b1);
    bend = 1; req = 1; tick(1); bend = 0; req = 0;
    chk("R10 pause sticky", sus, 1'b1);
    rel = 1; tick(1); rel = 0;
    chk("R9 release suspend", sus, 1'b0);
    chk("R9 release permit", perm, 1'b0);
    req = 1; bend = 1; tick(1); req = 0; bend = 0;
    chk("R7 request at boundary", sus, 1'b1);
    rel = 1; tick(1); rel = 0;
    req = 1; rel = 1; bend = 1; tick(1); req = 0; rel = 0; bend = 0;
    chk("R9 release beats request", sus, 1'b0);
    req = 1; tick(1); req = 0;
    act = 0; tick(1); act = 1;
    bend = 1; tick(1); bend = 0;
    chk("R10 request dropped", sus, 1'b0);
    req = 1; bend = 1; tick(1); req = 0; bend = 0;
    rel = 1; tick(1); rel = 0;
    chk("R9 release while paused", perm, 1'b0);

    // random phase, model compared on every clock
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 300) == 0) wide = ~wide;
      if (($urandom % 100) == 0) act = ~act;
      bend = act && !bend && (($urandom % 12) == 0);
      dat1 = (($urandom % 4) != 0);
      req  = (($urandom % 20) == 0);
      rel  = (($urandom % 30) == 0);
      ack  = (($urandom % 15) == 0);
      tick(1);
    end
    bend = 0; req = 0; rel = 0; ack = 0; dat1 = 1;
    tick(2);
    finish_run();
  end

endmodule